// File: doc/BRIEF.md
# Password-Gated Secure Region Guard

This block stands between a processor bus and a protected memory region and decides who may see the region's contents. A 128-bit password sits in eight 16-bit flash words. Software first reads each of those words once; these are dummy reads, and the block keeps the returned values as they pass. Software then writes its own 128-bit key into eight write-only key words. Once every password word has been read since the last key write or reset, the block compares the stored password with the key.

There are two unlock levels. A full match of all 128 bits opens the region to every master. A match of the lower 64 bits opens only the debug level. At that level a connected debugger may step through secure code, but its reads of secure data still return zeros. If the lower four password words are all ones, the debug level needs no key match, but the dummy reads are still required. Any access to the secure region while a debugger is attached and the debug level is closed trips the block. The trip holds the debug port disabled until reset. Password reads take a fixed 16 wait states.

Top module: `secmem_guard`

## Requirements
- R1: After reset, full_unlocked, dbg_unlocked and dbg_port_off are 0, the dummy-read record is empty and all key words are zero.
- R2: full_unlocked rises one clock after the last password read completes, when all eight key words equal the eight stored password words. Word i is bits [16i+15:16i], at key address 0x00+i and password address 0x10+i.
- R3: dbg_unlocked rises one clock after the last password read completes, when key words 0 to 3 equal password words 0 to 3, whatever the upper four words hold.
- R4: If password words 0 to 3 are all 16'hFFFF, dbg_unlocked rises once all eight words have been read, with any key value.
- R5: Neither flag is granted until each of the eight password words has completed a read since the last key write or reset. Any key write (address 0x00-0x07) clears both flags and the read record at that clock edge.
- R6: A request to the secure region (addresses 0x80-0xFF) while dbg_connected=1 and dbg_unlocked=0 sets dbg_port_off at the next edge. It then stays 1 until reset, even if a key unlock follows.
- R7: A read of the secure region returns mem_rdata only when full_unlocked=1, or when the access comes from secure code (bus_src_secure=1) and not from the debugger. In every other case it returns 0. A completing password read returns mem_rdata only when full_unlocked=1, otherwise 0.
- R8: mem_we is asserted for a write to the secure region only under the permission of R7. Otherwise the write is dropped.
- R9: A password read held on the bus completes with bus_ready on its 17th cycle (16 wait states). Every other request is ready in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read or fetch |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_src_secure | input | 1 | Access issued by code running from the secure region |
| bus_from_dbg | input | 1 | Access issued by the debug probe |
| dbg_connected | input | 1 | Debug probe attached |
| mem_rdata | input | 16 | Read data from flash/secure memory for bus_addr |
| bus_rdata | output | 16 | Filtered read data to the bus |
| bus_ready | output | 1 | Request completes this cycle |
| mem_we | output | 1 | Write strobe to secure memory |
| full_unlocked | output | 1 | 128-bit match achieved |
| dbg_unlocked | output | 1 | Debug level open |
| dbg_port_off | output | 1 | Sticky trip, debug port disabled |

## Verification
The hardest state to reach is the split one: the debug level open while full access stays closed. A debugger is attached, secure code runs without tripping, and debug reads still come back as zeros. The stimulus reaches it in two ways. One key matches the lower four words but has a flipped bit in an upper word. The other path uses a password image whose lower half is all ones. In both cases all eight 17-cycle password reads are repeated after each key write. A cycle-accurate reference model then checks every output on every clock, so it also catches stale-flag and trip-timing faults between the named checks.

// File: rtl/secg_pkg.sv
package secg_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  // debug level opens on a lower-half match or an unprogrammed lower half
  function automatic logic dbg_grant(input logic low_eq, input logic low_blank);
    return low_eq | low_blank;
  endfunction
endpackage

// File: rtl/secg_pwread.sv
module secg_pwread
  import secg_pkg::*;
#(
  parameter int NWORDS  = 8,
  parameter int PW_WAIT = 16,
  localparam int IDX_W  = $clog2(NWORDS),
  localparam int CNT_W  = $clog2(PW_WAIT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_go,
  input  logic                          clr,
  input  logic [IDX_W-1:0]              idx,
  input  word_t                         rdata,
  output logic                          done,
  output logic [NWORDS-1:0]             seen,
  output logic [NWORDS-1:0][WORD_W-1:0] pw
);
  logic [CNT_W-1:0] wait_cnt;

  assign done = rd_go && (wait_cnt == CNT_W'(PW_WAIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
    end else if (!rd_go || done) begin
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
      pw   <= '0;
    end else if (clr) begin
      seen <= '0;
    end else if (done) begin
      seen[idx] <= 1'b1;
      pw[idx]   <= rdata;
    end
  end

  generate
    if (PW_WAIT > 0) begin : g_pulse_chk
      p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    end
  endgenerate
endmodule

// File: rtl/secg_unlock.sv
module secg_unlock
  import secg_pkg::*;
#(
  parameter int NWORDS    = 8,
  parameter int LOW_WORDS = 4,
  localparam int IDX_W    = $clog2(NWORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          key_wr,
  input  logic [IDX_W-1:0]              idx,
  input  word_t                         wdata,
  input  logic [NWORDS-1:0]             seen,
  input  logic [NWORDS-1:0][WORD_W-1:0] pw,
  output logic                          full_q,
  output logic                          dbg_q
);
  logic [NWORDS-1:0][WORD_W-1:0] key_q;
  logic [NWORDS-1:0]             word_eq;
  logic [NWORDS-1:0]             word_blank;
  logic                          reads_done;
  logic                          all_eq;
  logic                          low_eq;
  logic                          low_blank;

  generate
    for (genvar i = 0; i < NWORDS; i++) begin : g_cmp
      assign word_eq[i]    = (key_q[i] == pw[i]);
      assign word_blank[i] = &pw[i];
    end
  endgenerate

  assign reads_done = &seen;
  assign all_eq     = &word_eq;
  assign low_eq     = &word_eq[LOW_WORDS-1:0];
  assign low_blank  = &word_blank[LOW_WORDS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      full_q <= 1'b0;
      dbg_q  <= 1'b0;
    end else begin
      if (key_wr) key_q[idx] <= wdata;
      full_q <= !key_wr && reads_done && all_eq;
      dbg_q  <= !key_wr && reads_done && dbg_grant(low_eq, low_blank);
    end
  end

  p_keywr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (!full_q && !dbg_q));
  p_full_implies_dbg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> dbg_q);
  p_unlock_needs_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q |-> reads_done);
endmodule

// File: rtl/secg_gate.sv
module secg_gate
  import secg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  we,
  input  logic  in_sec,
  input  logic  pw_done,
  input  logic  src_sec,
  input  logic  from_dbg,
  input  logic  dbg_conn,
  input  logic  full,
  input  logic  dbg_ok,
  input  word_t mem_rdata,
  output word_t rdata,
  output logic  mem_we,
  output logic  trip
);
  logic allow;
  logic sec_rd;
  logic trip_evt;

  assign allow    = full || (src_sec && !from_dbg);
  assign sec_rd   = req && !we && in_sec && allow;
  assign rdata    = (sec_rd || (pw_done && full)) ? mem_rdata : '0;
  assign mem_we   = req && we && in_sec && allow;
  assign trip_evt = req && in_sec && dbg_conn && !dbg_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trip <= 1'b0;
    else if (trip_evt) trip <= 1'b1;
  end

  p_trip_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> trip);
endmodule

// File: rtl/secmem_guard.sv
module secmem_guard
  import secg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NWORDS    = 8,
  parameter int LOW_WORDS = 4,
  parameter int PW_WAIT   = 16,
  parameter int SEC_LOG2  = 7,
  parameter logic [ADDR_W-1:0] KEY_BASE = 8'h00,
  parameter logic [ADDR_W-1:0] PW_BASE  = 8'h10,
  parameter logic [ADDR_W-1:0] SEC_BASE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_src_secure,
  input  logic              bus_from_dbg,
  input  logic              dbg_connected,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_ready,
  output logic              mem_we,
  output logic              full_unlocked,
  output logic              dbg_unlocked,
  output logic              dbg_port_off
);
  localparam int IDX_W = $clog2(NWORDS);

  logic                          in_key, in_pw, in_sec;
  logic                          key_wr, pw_rd, pw_done;
  logic [IDX_W-1:0]              idx;
  logic [NWORDS-1:0]             seen;
  logic [NWORDS-1:0][WORD_W-1:0] pw;

  // windows are aligned to their size, so only the upper bits are decoded
  assign in_key = (bus_addr[ADDR_W-1:IDX_W] == KEY_BASE[ADDR_W-1:IDX_W]);
  assign in_pw  = (bus_addr[ADDR_W-1:IDX_W] == PW_BASE[ADDR_W-1:IDX_W]);
  assign in_sec = (bus_addr[ADDR_W-1:SEC_LOG2] == SEC_BASE[ADDR_W-1:SEC_LOG2]);
  assign idx    = bus_addr[IDX_W-1:0];
  assign key_wr = bus_req && bus_we && in_key;
  assign pw_rd  = bus_req && !bus_we && in_pw;

  assign bus_ready = pw_rd ? pw_done : bus_req;

  secg_pwread #(.NWORDS(NWORDS), .PW_WAIT(PW_WAIT)) u_pwread (
    .clk(clk), .rst_n(rst_n), .rd_go(pw_rd), .clr(key_wr), .idx(idx),
    .rdata(mem_rdata), .done(pw_done), .seen(seen), .pw(pw)
  );

  secg_unlock #(.NWORDS(NWORDS), .LOW_WORDS(LOW_WORDS)) u_unlock (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .idx(idx), .wdata(bus_wdata),
    .seen(seen), .pw(pw), .full_q(full_unlocked), .dbg_q(dbg_unlocked)
  );

  secg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .in_sec(in_sec),
    .pw_done(pw_done), .src_sec(bus_src_secure), .from_dbg(bus_from_dbg),
    .dbg_conn(dbg_connected), .full(full_unlocked), .dbg_ok(dbg_unlocked),
    .mem_rdata(mem_rdata), .rdata(bus_rdata), .mem_we(mem_we),
    .trip(dbg_port_off)
  );

  p_dbg_read_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_from_dbg && !full_unlocked) |-> (bus_rdata == '0));
  p_no_unlock_after_trip_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && in_sec && dbg_connected && !dbg_unlocked) |=> dbg_port_off);
endmodule

// File: tb/tb_secmem_guard.sv
module tb_secmem_guard;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        rst_n, bus_req, bus_we, bus_src_secure, bus_from_dbg, dbg_connected;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata, mem_rdata, bus_rdata;
  logic        bus_ready, mem_we, full_unlocked, dbg_unlocked, dbg_port_off;

  secmem_guard dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [15:0] pw_img [8];

  always_comb begin
    if (bus_addr[7:3] == 5'b00010) mem_rdata = pw_img[bus_addr[2:0]];
    else                            mem_rdata = {bus_addr, ~bus_addr};
  end

  function automatic bit a_key(logic [7:0] a); return a[7:3] == 5'd0; endfunction
  function automatic bit a_pw (logic [7:0] a); return a[7:3] == 5'd2; endfunction
  function automatic bit a_sec(logic [7:0] a); return a[7];           endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [15:0] m_key [8];
  logic [15:0] m_pw  [8];
  logic [7:0]  m_seen;
  int          m_cnt;
  bit          m_full, m_dbg, m_trip;

  always @(posedge clk or negedge rst_n) begin : model
    bit pwrd, fin, all_eq, low_eq, low_ff, n_full, n_dbg;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_key[i] = '0; m_pw[i] = '0; end
      m_seen = '0; m_cnt = 0; m_full = 0; m_dbg = 0; m_trip = 0;
    end else begin
      pwrd = bus_req && !bus_we && a_pw(bus_addr);
      fin  = pwrd && (m_cnt == 16);
      all_eq = 1; low_eq = 1; low_ff = 1;
      for (int i = 0; i < 8; i++) begin
        if (m_key[i] != m_pw[i]) begin all_eq = 0; if (i < 4) low_eq = 0; end
        if (i < 4 && m_pw[i] != 16'hFFFF) low_ff = 0;
      end
      n_full = (m_seen == 8'hFF) && all_eq;
      n_dbg  = (m_seen == 8'hFF) && (low_eq || low_ff);
      if (bus_req && a_sec(bus_addr) && dbg_connected && !m_dbg) m_trip = 1;
      if (bus_req && bus_we && a_key(bus_addr)) begin
        m_key[bus_addr[2:0]] = bus_wdata;
        m_seen = '0; n_full = 0; n_dbg = 0;
      end
      if (fin) begin
        m_pw[bus_addr[2:0]] = mem_rdata;
        m_seen[bus_addr[2:0]] = 1'b1;
        m_cnt = 0;
      end else if (pwrd) m_cnt++;
      else m_cnt = 0;
      m_full = n_full; m_dbg = n_dbg;
    end
  end

  always @(negedge clk) begin : cmp
    bit pwrd, e_rdy, allow, e_show;
    pwrd  = bus_req && !bus_we && a_pw(bus_addr);
    e_rdy = pwrd ? (m_cnt == 16) : bus_req;
    allow = m_full || (bus_src_secure && !bus_from_dbg);
    e_show = (bus_req && !bus_we && a_sec(bus_addr) && allow) || (pwrd && e_rdy && m_full);
    chk("R2 full_unlocked", 16'(full_unlocked), 16'(m_full));
    chk("R3 dbg_unlocked",  16'(dbg_unlocked),  16'(m_dbg));
    chk("R6 dbg_port_off",  16'(dbg_port_off),  16'(m_trip));
    chk("R9 bus_ready",     16'(bus_ready),     16'(e_rdy));
    chk("R7 bus_rdata",     bus_rdata, e_show ? mem_rdata : 16'h0);
    chk("R8 mem_we",        16'(mem_we), 16'(bus_req && bus_we && a_sec(bus_addr) && allow));
  end

  task automatic bus_op(input logic [7:0] a, input logic we, input logic [15:0] d,
                        input logic src, input logic dbg,
                        output logic [15:0] rd, output logic wes, output int cyc);
    @(posedge clk); #1;
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    bus_src_secure = src; bus_from_dbg = dbg; cyc = 0;
    forever begin
      @(negedge clk); cyc++;
      if (bus_ready) begin rd = bus_rdata; wes = mem_we; break; end
    end
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0; bus_src_secure = 0; bus_from_dbg = 0;
  endtask

  logic [15:0] rd;
  logic        wes;
  int          cyc;

  task automatic wr_key(input int i, input logic [15:0] d);
    bus_op(8'(i), 1'b1, d, 1'b0, 1'b0, rd, wes, cyc);
  endtask
  task automatic rd_pw(input int i);
    bus_op(8'h10 + 8'(i), 1'b0, 16'h0, 1'b0, 1'b0, rd, wes, cyc);
  endtask
  task automatic rd_pw_all();
    for (int i = 0; i < 8; i++) rd_pw(i);
    @(posedge clk); @(negedge clk);
  endtask
  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    bus_src_secure = 0; bus_from_dbg = 0; dbg_connected = 0;
    for (int i = 0; i < 8; i++) pw_img[i] = 16'h3C5A ^ (16'(i) * 16'h1111);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset full", 16'(full_unlocked), 16'h0);
    chk("R1 reset dbg",  16'(dbg_unlocked),  16'h0);
    chk("R1 reset trip", 16'(dbg_port_off),  16'h0);

    // correct key, dummy reads, wait-state timing
    for (int i = 0; i < 8; i++) wr_key(i, pw_img[i]);
    rd_pw(0);
    chk("R9 password read cycles", 16'(cyc), 16'd17);
    chk("R7 locked password read", rd, 16'h0);
    for (int i = 1; i < 8; i++) rd_pw(i);
    @(posedge clk); @(negedge clk);
    chk("R2 full after match", 16'(full_unlocked), 16'h1);
    chk("R3 dbg follows full", 16'(dbg_unlocked), 16'h1);
    rd_pw(3);
    chk("R7 unlocked password read", rd, pw_img[3]);
    bus_op(8'h90, 1'b0, 16'h0, 1'b0, 1'b1, rd, wes, cyc);
    chk("R7 debug read when full", rd, 16'h906F);
    chk("R9 plain access cycles", 16'(cyc), 16'd1);
    bus_op(8'h85, 1'b1, 16'hBEEF, 1'b0, 1'b0, rd, wes, cyc);
    chk("R8 write passes when full", 16'(wes), 16'h1);

    // upper-half bit error: debug only
    wr_key(5, pw_img[5] ^ 16'h0100);
    @(negedge clk);
    chk("R5 key write clears full", 16'(full_unlocked), 16'h0);
    chk("R5 key write clears dbg",  16'(dbg_unlocked), 16'h0);
    rd_pw_all();
    chk("R3 lower match full", 16'(full_unlocked), 16'h0);
    chk("R3 lower match dbg",  16'(dbg_unlocked), 16'h1);
    dbg_connected = 1;
    bus_op(8'hA0, 1'b0, 16'h0, 1'b0, 1'b1, rd, wes, cyc);
    chk("R7 debug read blanked", rd, 16'h0);
    bus_op(8'hA1, 1'b0, 16'h0, 1'b1, 1'b0, rd, wes, cyc);
    chk("R7 secure fetch sees data", rd, 16'hA15E);
    bus_op(8'hA2, 1'b1, 16'h1234, 1'b0, 1'b1, rd, wes, cyc);
    chk("R8 debug write dropped", 16'(wes), 16'h0);
    @(negedge clk);
    chk("R6 no trip when dbg open", 16'(dbg_port_off), 16'h0);
    dbg_connected = 0;

    // single-bit error in lower half
    wr_key(5, pw_img[5]);
    wr_key(0, pw_img[0] ^ 16'h0001);
    rd_pw_all();
    chk("R3 lower bit error dbg", 16'(dbg_unlocked), 16'h0);
    chk("R2 lower bit error full", 16'(full_unlocked), 16'h0);

    // skipped dummy read
    wr_key(0, pw_img[0]);
    for (int i = 0; i < 7; i++) rd_pw(i);
    @(posedge clk); @(negedge clk);
    chk("R5 seven reads full", 16'(full_unlocked), 16'h0);
    chk("R5 seven reads dbg",  16'(dbg_unlocked), 16'h0);
    rd_pw(7);
    @(posedge clk); @(negedge clk);
    chk("R5 eighth read unlocks", 16'(full_unlocked), 16'h1);

    // unprogrammed lower half
    for (int i = 0; i < 4; i++) pw_img[i] = 16'hFFFF;
    wr_key(2, 16'h0BAD);
    for (int i = 0; i < 7; i++) rd_pw(i);
    @(posedge clk); @(negedge clk);
    chk("R4 blank still needs reads", 16'(dbg_unlocked), 16'h0);
    rd_pw(7);
    @(posedge clk); @(negedge clk);
    chk("R4 blank lower dbg", 16'(dbg_unlocked), 16'h1);
    chk("R4 blank lower full", 16'(full_unlocked), 16'h0);

    // trip and stickiness
    do_reset();
    @(negedge clk);
    chk("R1 reset clears flags", 16'(dbg_unlocked), 16'h0);
    dbg_connected = 1;
    bus_op(8'hC4, 1'b0, 16'h0, 1'b1, 1'b0, rd, wes, cyc);
    @(negedge clk);
    chk("R6 trip on locked access", 16'(dbg_port_off), 16'h1);
    dbg_connected = 0;
    for (int i = 0; i < 8; i++) wr_key(i, pw_img[i]);
    rd_pw_all();
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R6 unlock keeps trip", 16'(full_unlocked), 16'h1);
    chk("R6 trip sticky", 16'(dbg_port_off), 16'h1);
    do_reset();
    @(negedge clk);
    chk("R1 reset clears trip", 16'(dbg_port_off), 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule